// File: doc/BRIEF.md
# Shared Interrupt State Register Bank

This block keeps the configuration and run-time state of every shared peripheral interrupt: group, enable, pending, active, an 8-bit priority, a level/edge trigger choice and a 2-bit access level that applies to requests from the non-secure side. Software reaches the state through a simple single-cycle bus port. The port carries an address, a byte count of 1, 2 or 4, write data, a combinational read result and a flag that marks the access as secure. Enable, pending and active state is changed through paired set and clear windows, so one write can flip single bits without a read-modify-write sequence.

The complete state is driven out as flat vectors for a downstream arbiter. One cycle after any write that really changes group, enable, pending, active or priority state, a single-cycle update strobe tells the arbiter to re-evaluate. An interrupt whose group bit is 0 counts as secure. A non-secure request that touches such an interrupt is filtered per bit, using that interrupt's access level.

Top module: `irq_state_bank`

## Requirements
- R1: The bit windows hold one bit per interrupt: group at 0x080, set-enable at 0x100, clear-enable at 0x180, set-pending at 0x200, clear-pending at 0x280, set-active at 0x300 and clear-active at 0x380, each 0x80 bytes long. An access at offset k from a window base covers IDs 8k up to 8k+8N-1 for N bytes, with the lowest ID on data bit 0. In the group window a write stores each bit as given. In a set window a 1 sets the bit; in a clear window a 1 clears it. A 0 in either leaves the bit alone, and a read of either window of a pair returns the current state.
- R2: The priority window at 0x400–0x7FF holds one byte per interrupt at byte offset equal to the ID. Byte j of the data belongs to ID offset+j.
- R3: The configuration window at 0xC00–0xCFF holds two bits per interrupt, with first ID = 4 × offset. For each interrupt the even bit reads 0 and ignores writes. The odd bit is the trigger type: 0 means level, 1 means edge.
- R4: The access-level window at 0xE00–0xEFF holds two bits per interrupt, with first ID = 4 × offset. Reads of this window and of the group window from the non-secure side return 0, and writes from that side are ignored.
- R5: An interrupt with group bit 0 is secure. A non-secure access to its enable, priority or configuration state reads 0 and ignores writes.
- R6: For a secure interrupt, a non-secure set-pending access works only when the access level is not 0. Otherwise the bit reads 0 and the write is ignored.
- R7: For a secure interrupt, non-secure clear-pending, set-active and clear-active accesses work only when the access level is 2 or 3. Otherwise the bit reads 0 and the write is ignored.
- R8: IDs below 32 and IDs at or above NUM_LINES hold no state. Their bits read 0, and writes to them change nothing and raise no strobe.
- R9: The window 0x800–0x8FF reads 0 and ignores writes. A read of address 0xFFE0 returns 0x92.
- R10: upd_o is high for exactly the cycle after a write that changed group, enable, pending, active or priority state. It stays low after writes that change nothing or change only trigger or access-level state.
- R11: After reset all state is zero: every interrupt is group 0, disabled, idle, priority 0, level-triggered and at access level 0. upd_o is low.
- R12: The state vectors show the result of a write from the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sec | input | 1 | 1 = secure access |
| bus_addr | input | 16 | Byte address of the access |
| bus_size | input | 3 | Byte count: 1, 2 or 4 |
| bus_wdata | input | 32 | Write data, lowest ID on low bits |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read |
| grp_o | output | NUM_LINES | Group bit per interrupt |
| en_o | output | NUM_LINES | Enable bit per interrupt |
| pend_o | output | NUM_LINES | Pending bit per interrupt |
| act_o | output | NUM_LINES | Active bit per interrupt |
| edge_o | output | NUM_LINES | Edge-triggered flag per interrupt |
| prio_o | output | 8*NUM_LINES | Priority bytes, ID n at bits 8n+7:8n |
| upd_o | output | 1 | One-cycle strobe after a state-changing write |

## Verification
Writes are issued as full words, as single bytes and as half words at unaligned window offsets. This shows that the ID mapping in the three field widths (bit, pair and byte) moves with offset and size, and is not fixed to lane 0. Secure and non-secure accesses go to the same interrupts at access levels 0, 1 and 2. Each of these three levels passes a different subset of the pending and active windows, so the results separate the set-pending threshold from the clear and active threshold. Writes that change nothing, and writes only to the trigger window, are mixed in with changing writes. This separates a strobe driven by actual state change from one driven by bus activity.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  typedef enum logic [3:0] {
    WIN_NONE, WIN_GRP, WIN_SEN, WIN_CEN, WIN_SPND, WIN_CPND,
    WIN_SACT, WIN_CACT, WIN_PRIO, WIN_CFG, WIN_ACL, WIN_TGT, WIN_PID
  } win_e;

  localparam int unsigned FIRST_SHARED_ID = 32;
  localparam logic [15:0] PID_ADDR        = 16'hFFE0;
  localparam logic [7:0]  PID_VALUE       = 8'h92;
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int AW = 16,
  localparam int FW = AW + 3
) (
  input  logic [AW-1:0] addr,
  output win_e          win,
  output logic [FW-1:0] first_id
);
  logic [AW-1:0] off;

  always_comb begin
    win = WIN_NONE;
    off = '0;
    first_id = '0;
    if (addr >= AW'('h080) && addr <= AW'('h0FF)) begin
      win = WIN_GRP;  off = addr - AW'('h080);
    end else if (addr >= AW'('h100) && addr <= AW'('h17F)) begin
      win = WIN_SEN;  off = addr - AW'('h100);
    end else if (addr >= AW'('h180) && addr <= AW'('h1FF)) begin
      win = WIN_CEN;  off = addr - AW'('h180);
    end else if (addr >= AW'('h200) && addr <= AW'('h27F)) begin
      win = WIN_SPND; off = addr - AW'('h200);
    end else if (addr >= AW'('h280) && addr <= AW'('h2FF)) begin
      win = WIN_CPND; off = addr - AW'('h280);
    end else if (addr >= AW'('h300) && addr <= AW'('h37F)) begin
      win = WIN_SACT; off = addr - AW'('h300);
    end else if (addr >= AW'('h380) && addr <= AW'('h3FF)) begin
      win = WIN_CACT; off = addr - AW'('h380);
    end else if (addr >= AW'('h400) && addr <= AW'('h7FF)) begin
      win = WIN_PRIO; off = addr - AW'('h400);
    end else if (addr >= AW'('h800) && addr <= AW'('h8FF)) begin
      win = WIN_TGT;
    end else if (addr >= AW'('hC00) && addr <= AW'('hCFF)) begin
      win = WIN_CFG;  off = addr - AW'('hC00);
    end else if (addr >= AW'('hE00) && addr <= AW'('hEFF)) begin
      win = WIN_ACL;  off = addr - AW'('hE00);
    end else if (addr == AW'(PID_ADDR)) begin
      win = WIN_PID;
    end

    case (win)
      WIN_PRIO:         first_id = FW'(off);
      WIN_CFG, WIN_ACL: first_id = {1'b0, off, 2'b00};
      default:          first_id = {off, 3'b000};
    endcase
  end
endmodule

// File: rtl/irq_bank_lane.sv
module irq_bank_lane
  import irq_bank_pkg::*;
#(
  parameter int ID = 32,
  parameter int FW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  win_e          win,
  input  logic [FW-1:0] first_id,
  input  logic [2:0]    nbytes,
  input  logic [31:0]   wdata,
  input  logic          sec,
  output logic          grp,
  output logic          en,
  output logic          pend,
  output logic          act,
  output logic          edge_cfg,
  output logic [7:0]    prio,
  output logic [31:0]   rd_part,
  output logic          chg
);
  logic       grp_q, en_q, pend_q, act_q, edge_q;
  logic [7:0] prio_q;
  logic [1:0] acl_q;
  logic       grp_n, en_n, pend_n, act_n, edge_n;
  logic [7:0] prio_n;
  logic [1:0] acl_n;

  int         rel, nb;
  logic       hit_bit, hit_byte, hit_pair, hit, ok, sel, ns_sec, wb;
  logic [4:0] pos;

  // coverage and permission of this interrupt for the current access
  always_comb begin
    rel      = ID - int'(first_id);
    nb       = (nbytes == 3'd0 || nbytes > 3'd4) ? 4 : int'(nbytes);
    hit_bit  = (rel >= 0) && (rel < 8 * nb);
    hit_byte = (rel >= 0) && (rel < nb);
    hit_pair = (rel >= 0) && (rel < 4 * nb);
    ns_sec   = !sec && !grp_q;
    hit      = 1'b0;
    ok       = 1'b0;
    pos      = rel[4:0];
    case (win)
      WIN_GRP:            begin hit = hit_bit;  ok = sec; end
      WIN_SEN, WIN_CEN:   begin hit = hit_bit;  ok = !ns_sec; end
      WIN_SPND:           begin hit = hit_bit;  ok = !ns_sec || (acl_q != 2'd0); end
      WIN_CPND, WIN_SACT,
      WIN_CACT:           begin hit = hit_bit;  ok = !ns_sec || (acl_q >= 2'd2); end
      WIN_PRIO:           begin hit = hit_byte; ok = !ns_sec; pos = {rel[1:0], 3'b000}; end
      WIN_CFG:            begin hit = hit_pair; ok = !ns_sec; pos = {rel[3:0], 1'b0}; end
      WIN_ACL:            begin hit = hit_pair; ok = sec;     pos = {rel[3:0], 1'b0}; end
      default:            ;
    endcase
    sel = hit && ok;
  end

  // read contribution
  always_comb begin
    rd_part = '0;
    if (sel) begin
      case (win)
        WIN_GRP:            rd_part = 32'(grp_q)  << pos;
        WIN_SEN, WIN_CEN:   rd_part = 32'(en_q)   << pos;
        WIN_SPND, WIN_CPND: rd_part = 32'(pend_q) << pos;
        WIN_SACT, WIN_CACT: rd_part = 32'(act_q)  << pos;
        WIN_PRIO:           rd_part = 32'(prio_q) << pos;
        WIN_CFG:            rd_part = 32'({edge_q, 1'b0}) << pos;
        WIN_ACL:            rd_part = 32'(acl_q)  << pos;
        default:            ;
      endcase
    end
  end

  // next state
  always_comb begin
    grp_n = grp_q; en_n = en_q; pend_n = pend_q; act_n = act_q;
    edge_n = edge_q; prio_n = prio_q; acl_n = acl_q;
    wb = wdata[pos];
    if (wr && sel) begin
      case (win)
        WIN_GRP:  grp_n = wb;
        WIN_SEN:  if (wb) en_n = 1'b1;
        WIN_CEN:  if (wb) en_n = 1'b0;
        WIN_SPND: if (wb) pend_n = 1'b1;
        WIN_CPND: if (wb) pend_n = 1'b0;
        WIN_SACT: if (wb) act_n = 1'b1;
        WIN_CACT: if (wb) act_n = 1'b0;
        WIN_PRIO: prio_n = wdata[pos +: 8];
        WIN_CFG:  edge_n = wdata[pos + 5'd1];
        WIN_ACL:  acl_n = wdata[pos +: 2];
        default:  ;
      endcase
    end
    chg = {grp_n, en_n, pend_n, act_n, prio_n} != {grp_q, en_q, pend_q, act_q, prio_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= 1'b0; en_q <= 1'b0; pend_q <= 1'b0; act_q <= 1'b0;
      edge_q <= 1'b0; prio_q <= '0; acl_q <= '0;
    end else if (wr) begin
      grp_q <= grp_n; en_q <= en_n; pend_q <= pend_n; act_q <= act_n;
      edge_q <= edge_n; prio_q <= prio_n; acl_q <= acl_n;
    end
  end

  assign grp = grp_q;
  assign en = en_q;
  assign pend = pend_q;
  assign act = act_q;
  assign edge_cfg = edge_q;
  assign prio = prio_q;

  a_r5_ns_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (win == WIN_SEN || win == WIN_CEN) && hit_bit && !sec && !grp_q) |=> $stable(en_q));
  a_r5_ns_prio_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && win == WIN_PRIO && hit_byte && !sec && !grp_q) |=> $stable(prio_q));
  a_r6_set_pend_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && win == WIN_SPND && hit_bit && !sec && !grp_q && acl_q == 2'd0) |=> $stable(pend_q));
  a_r7_clr_pend_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && win == WIN_CPND && hit_bit && !sec && !grp_q && acl_q < 2'd2) |=> $stable(pend_q));
  a_r7_active_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (win == WIN_SACT || win == WIN_CACT) && hit_bit && !sec && !grp_q && acl_q < 2'd2)
    |=> $stable(act_q));
  a_r4_acl_ns_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && win == WIN_ACL && !sec) |=> $stable(acl_q));
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int AW        = 16,
  localparam int FW       = AW + 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_req,
  input  logic                   bus_we,
  input  logic                   bus_sec,
  input  logic [AW-1:0]          bus_addr,
  input  logic [2:0]             bus_size,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic [NUM_LINES-1:0]   grp_o,
  output logic [NUM_LINES-1:0]   en_o,
  output logic [NUM_LINES-1:0]   pend_o,
  output logic [NUM_LINES-1:0]   act_o,
  output logic [NUM_LINES-1:0]   edge_o,
  output logic [8*NUM_LINES-1:0] prio_o,
  output logic                   upd_o
);
  logic [1:0]           rst_sync;
  logic                 rst_i_n;
  win_e                 win;
  logic [FW-1:0]        first_id;
  logic                 wr, upd_d, upd_q;
  logic [NUM_LINES-1:0] chg_v;
  logic [31:0]          rd_part [NUM_LINES];
  logic [31:0]          rd_or;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign wr = bus_req && bus_we;

  irq_bank_decode #(.AW(AW)) u_dec (
    .addr(bus_addr), .win(win), .first_id(first_id)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    if (g < FIRST_SHARED_ID) begin : g_none
      assign grp_o[g] = 1'b0;
      assign en_o[g] = 1'b0;
      assign pend_o[g] = 1'b0;
      assign act_o[g] = 1'b0;
      assign edge_o[g] = 1'b0;
      assign prio_o[8*g +: 8] = 8'h00;
      assign rd_part[g] = '0;
      assign chg_v[g] = 1'b0;
    end else begin : g_lane
      irq_bank_lane #(.ID(g), .FW(FW)) u_lane (
        .clk(clk), .rst_n(rst_i_n), .wr(wr), .win(win), .first_id(first_id),
        .nbytes(bus_size), .wdata(bus_wdata), .sec(bus_sec),
        .grp(grp_o[g]), .en(en_o[g]), .pend(pend_o[g]), .act(act_o[g]),
        .edge_cfg(edge_o[g]), .prio(prio_o[8*g +: 8]),
        .rd_part(rd_part[g]), .chg(chg_v[g])
      );
    end
  end

  always_comb begin
    rd_or = '0;
    for (int i = 0; i < NUM_LINES; i++) rd_or = rd_or | rd_part[i];
    bus_rdata = '0;
    if (bus_req && !bus_we)
      bus_rdata = (win == WIN_PID) ? 32'(PID_VALUE) : rd_or;
    upd_d = wr && (|chg_v);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) upd_q <= 1'b0;
    else          upd_q <= upd_d;
  end
  assign upd_o = upd_q;

  a_r10_upd_follows_write: assert property (@(posedge clk) disable iff (!rst_i_n)
    upd_o |-> $past(bus_req && bus_we));
  a_r9_target_raz: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_req && !bus_we && win == WIN_TGT) |-> bus_rdata == 32'h0);
  a_r8_low_ids_empty: assert property (@(posedge clk) disable iff (!rst_i_n)
    (en_o[FIRST_SHARED_ID-1:0] == '0) && (pend_o[FIRST_SHARED_ID-1:0] == '0));
  a_r10_no_upd_on_read: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_req && !bus_we) |=> !upd_o);
endmodule

// File: tb/tb_irq_state_bank.sv
module tb_irq_state_bank;
  localparam int NL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0, bus_sec = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [2:0]    bus_size = 3'd4;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] grp_o, en_o, pend_o, act_o, edge_o;
  logic [8*NL-1:0] prio_o;
  logic          upd_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  irq_state_bank #(.NUM_LINES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_sec(bus_sec),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .grp_o(grp_o), .en_o(en_o), .pend_o(pend_o),
    .act_o(act_o), .edge_o(edge_o), .prio_o(prio_o), .upd_o(upd_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // write; returns at the negedge after the accepting edge
  task automatic wr(input logic [15:0] a, input logic [2:0] n, input logic [31:0] d, input logic s);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = n; bus_wdata = d; bus_sec = s;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [2:0] n, input logic s, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = n; bus_sec = s;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 grp", 64'(grp_o), 64'h0);
    chk("R11 en", 64'(en_o | pend_o | act_o | edge_o), 64'h0);
    chk("R11 prio", 64'(|prio_o), 64'h0);
    chk("R11 upd", 64'(upd_o), 64'h0);
  endtask

  task automatic t_group_enable();
    logic [31:0] d;
    wr(16'h084, 3'd4, 32'hFFFF_0000, 1'b1);
    chk("R12 grp after write", 64'(grp_o), 64'hFFFF_0000_0000_0000);
    chk("R10 strobe on group change", 64'(upd_o), 64'h1);
    rd(16'h084, 3'd4, 1'b1, d);
    chk("R1 group read", 64'(d), 64'hFFFF_0000);
    wr(16'h104, 3'd4, 32'h0000_00F0, 1'b1);
    chk("R1 set-enable", 64'(en_o), 64'h0000_00F0_0000_0000);
    chk("R10 strobe on enable", 64'(upd_o), 64'h1);
    wr(16'h104, 3'd4, 32'h0, 1'b1);
    chk("R10 no strobe on zero write", 64'(upd_o), 64'h0);
    wr(16'h184, 3'd4, 32'h0000_0010, 1'b1);
    chk("R1 clear-enable", 64'(en_o), 64'h0000_00E0_0000_0000);
    rd(16'h104, 3'd4, 1'b1, d);
    chk("R1 read set window", 64'(d), 64'hE0);
    rd(16'h184, 3'd4, 1'b1, d);
    chk("R1 read clear window", 64'(d), 64'hE0);
    wr(16'h105, 3'd1, 32'h0000_0001, 1'b1);
    chk("R1 byte access offset", 64'(en_o), 64'h0000_01E0_0000_0000);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    wr(16'h420, 3'd4, 32'h4433_2211, 1'b1);
    chk("R2 prio id32", 64'(prio_o[8*32 +: 8]), 64'h11);
    chk("R2 prio id35", 64'(prio_o[8*35 +: 8]), 64'h44);
    rd(16'h421, 3'd1, 1'b1, d);
    chk("R2 prio byte read", 64'(d), 64'h22);
    wr(16'h421, 3'd1, 32'h0000_00FF, 1'b0);
    chk("R5 ns prio write ignored", 64'(prio_o[8*33 +: 8]), 64'h22);
    chk("R10 no strobe when ignored", 64'(upd_o), 64'h0);
    rd(16'h421, 3'd1, 1'b0, d);
    chk("R5 ns prio read zero", 64'(d), 64'h0);
    wr(16'h430, 3'd1, 32'h0000_005A, 1'b0);
    chk("R5 ns prio on group1", 64'(prio_o[8*48 +: 8]), 64'h5A);
  endtask

  task automatic t_cfg_acl();
    logic [31:0] d;
    wr(16'hC08, 3'd4, 32'h0000_000E, 1'b1);
    chk("R3 edge bits", 64'(edge_o), 64'h0000_0003_0000_0000);
    chk("R10 no strobe for trigger", 64'(upd_o), 64'h0);
    rd(16'hC08, 3'd4, 1'b1, d);
    chk("R3 even bits zero", 64'(d), 64'hA);
    wr(16'hE08, 3'd4, 32'h0000_0024, 1'b1);
    rd(16'hE08, 3'd4, 1'b0, d);
    chk("R4 ns acl read zero", 64'(d), 64'h0);
    wr(16'hE08, 3'd4, 32'h0000_FFFF, 1'b0);
    rd(16'hE08, 3'd4, 1'b1, d);
    chk("R4 ns acl write ignored", 64'(d), 64'h24);
    wr(16'h084, 3'd4, 32'h0, 1'b0);
    chk("R4 ns group write ignored", 64'(grp_o), 64'hFFFF_0000_0000_0000);
    rd(16'h084, 3'd4, 1'b0, d);
    chk("R4 ns group read zero", 64'(d), 64'h0);
  endtask

  task automatic t_ns_pend_act();
    logic [31:0] d;
    // acl: id32=0, id33=1, id34=2
    wr(16'h204, 3'd4, 32'h0000_0007, 1'b0);
    chk("R6 ns set-pending by level", 64'(pend_o), 64'h0000_0006_0000_0000);
    rd(16'h204, 3'd4, 1'b0, d);
    chk("R6 ns pending read", 64'(d), 64'h6);
    wr(16'h284, 3'd4, 32'h0000_0006, 1'b0);
    chk("R7 ns clear-pending needs 2", 64'(pend_o), 64'h0000_0002_0000_0000);
    rd(16'h284, 3'd4, 1'b0, d);
    chk("R7 ns clear window hides level1", 64'(d), 64'h0);
    wr(16'h304, 3'd4, 32'h0000_0006, 1'b0);
    chk("R7 ns set-active", 64'(act_o), 64'h0000_0004_0000_0000);
    rd(16'h304, 3'd4, 1'b0, d);
    chk("R7 ns active read", 64'(d), 64'h4);
    wr(16'h206, 3'd2, 32'h0000_0001, 1'b0);
    chk("R1 halfword offset group1", 64'(pend_o), 64'h0001_0002_0000_0000);
    wr(16'h104, 3'd4, 32'hFFFF_FFFF, 1'b0);
    chk("R5 ns enable only group1", 64'(en_o), 64'hFFFF_01E0_0000_0000);
    rd(16'h104, 3'd4, 1'b0, d);
    chk("R5 ns enable read", 64'(d), 64'hFFFF_0000);
  endtask

  task automatic t_range_misc();
    logic [31:0] d;
    wr(16'h100, 3'd4, 32'hFFFF_FFFF, 1'b1);
    chk("R8 low ids no state", 64'(en_o), 64'hFFFF_01E0_0000_0000);
    chk("R8 no strobe", 64'(upd_o), 64'h0);
    rd(16'h100, 3'd4, 1'b1, d);
    chk("R8 low ids read zero", 64'(d), 64'h0);
    wr(16'h108, 3'd4, 32'hFFFF_FFFF, 1'b1);
    chk("R8 high ids no strobe", 64'(upd_o), 64'h0);
    rd(16'h108, 3'd4, 1'b1, d);
    chk("R8 high ids read zero", 64'(d), 64'h0);
    wr(16'h800, 3'd4, 32'hFFFF_FFFF, 1'b1);
    rd(16'h800, 3'd4, 1'b1, d);
    chk("R9 target window zero", 64'(d), 64'h0);
    rd(16'hFFE0, 3'd4, 1'b1, d);
    chk("R9 id register", 64'(d), 64'h92);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_group_enable();
    t_priority();
    t_cfg_acl();
    t_ns_pend_act();
    t_range_misc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule